// File: doc/BRIEF.md
# Numeric Status Word and Error Summary Unit

This block keeps the 16-bit status word of a floating-point unit. Six exception flags sit in the low bits and stay set once reported. A stack-fault flag records that an invalid operation came from the register stack, and one condition-code bit records the direction of that fault. Four condition codes and a 3-bit top-of-stack pointer are written by update strobes from the execution pipeline. The error-summary bit and its busy-bit copy are not stored. They are computed at every moment from the stored flags and a 6-bit mask that comes from the control word. The `error_out` pin follows the summary bit.

Software can restore the whole word in one cycle. The stored fields come from the loaded data, but the two summary bits are ignored and computed again, so a restore cannot assert ERROR by writing bit 7 or bit 15. A clear command zeroes the exception flags and the stack-fault flag.

Each cycle a small decoder picks one operation by priority. The operations are OP_LOAD (whole-word restore), then OP_CLEAR (clear exceptions), then OP_UPDATE (some report or field strobe is active), then OP_IDLE (no request). The decoder has no stored state: the operation is reselected every cycle from the command inputs, and any operation can follow any other. The register writes on the clock edge, and the operation chosen before that edge decides what is written.

Top module: `nsw_status_unit`

## Requirements
- R1: While `rst_n` is low, and after `rst_n` is released with no commands, `status_word` is 0x0000 and `error_out` is 0.
- R2: With no load or clear, every bit set in `exc_report[5:0]` is ORed into `status_word[5:0]` at the clock edge. Set bits stay set until a clear or a load changes them.
- R3: `status_word[7]` is 1 exactly when some bit i of `status_word[5:0]` is 1 while `exc_mask[i]` is 0 (mask 1 = masked). `status_word[15]` always equals `status_word[7]`.
- R4: `error_out` always equals `status_word[7]`.
- R5: A change on `exc_mask` alone changes bits 7 and 15 and `error_out` in the same cycle, with no clock edge needed. It leaves every stored bit unchanged.
- R6: When `cc_wr_en` is 1 (update cycle), the edge writes `cc_in[0]` to bit 8 (C0), `cc_in[1]` to bit 9 (C1), `cc_in[2]` to bit 10 (C2) and `cc_in[3]` to bit 14 (C3).
- R7: When `top_wr_en` is 1 (update cycle), the edge writes `top_in` to bits 13:11.
- R8: When `sf_report` is 1 (update cycle), the edge sets bit 6 (it stays set) and writes `sf_overflow` to bit 9: 1 for overflow, 0 for underflow. This value wins over a C1 write in the same cycle.
- R9: When `load_en` is 1, the edge takes bits 14:8 and 6:0 of `status_word` from `load_word`. `load_word[7]` and `load_word[15]` are ignored, and bits 7 and 15 are computed again as in R3. If the result is 1, `error_out` is 1 from the cycle after that edge.
- R10: The load has priority over every other request in that cycle: clear, reports and strobes are all ignored.
- R11: When `clear_en` is 1 and `load_en` is 0, the edge zeroes bits 6:0, so bits 7 and 15 and `error_out` drop to 0. Bits 14:8 are unchanged, and same-cycle reports and strobes are ignored.
- R12: In a cycle with no request, `status_word` stays as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_report | input | 6 | Newly detected exception flags, ORed in |
| sf_report | input | 1 | Stack fault detected this cycle |
| sf_overflow | input | 1 | Stack fault direction: 1 overflow, 0 underflow |
| cc_wr_en | input | 1 | Write strobe for the four condition codes |
| cc_in | input | 4 | Condition codes {C3,C2,C1,C0} |
| top_wr_en | input | 1 | Write strobe for top-of-stack pointer |
| top_in | input | 3 | New top-of-stack pointer |
| clear_en | input | 1 | Clear exception and stack-fault flags |
| load_en | input | 1 | Whole-word restore strobe |
| load_word | input | 16 | Word to restore |
| exc_mask | input | 6 | Exception masks from control word, 1 = masked |
| status_word | output | 16 | Current status word |
| error_out | output | 1 | Error summary output |

## Verification
The hardest cases are requests that collide in the same cycle. These are a load together with a clear and a report, a clear together with reports and field strobes, and a stack fault together with a C1 write of the opposite value. Only the priority order decides these, and ports driven one at a time never create them. The bench therefore drives these combinations in single cycles. It also restores words in which bits 7 and 15 are 1 while every flag is zero or masked. After that it moves the mask with no clock-edge command and checks `error_out` in the same cycle.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
    localparam int EXC_W  = 6;
    localparam int TOP_W  = 3;
    localparam int CC_W   = 4;
    localparam int WORD_W = 16;

    // Bit positions the rest of the unit decodes
    localparam int SF_BIT  = EXC_W;
    localparam int ES_BIT  = 7;
    localparam int C0_BIT  = 8;
    localparam int C1_BIT  = 9;
    localparam int C2_BIT  = 10;
    localparam int TOP_LSB = 11;
    localparam int TOP_MSB = TOP_LSB + TOP_W - 1;
    localparam int C3_BIT  = 14;
    localparam int B_BIT   = 15;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_UPDATE = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_LOAD   = 2'd3
    } nsw_op_e;
endpackage

// File: rtl/nsw_cmd_sel.sv
module nsw_cmd_sel
    import nsw_pkg::*;
(
    input  logic    load_en,
    input  logic    clear_en,
    input  logic    any_update,
    output nsw_op_e op
);
    always_comb begin
        if (load_en)
            op = OP_LOAD;
        else if (clear_en)
            op = OP_CLEAR;
        else if (any_update)
            op = OP_UPDATE;
        else
            op = OP_IDLE;
    end

    always_comb begin
        assert_load_wins_R10: assert (!load_en || op == OP_LOAD);
    end
endmodule

// File: rtl/nsw_flag_reg.sv
module nsw_flag_reg
    import nsw_pkg::*;
#(
    parameter int NUM_EXC = EXC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  nsw_op_e            op,
    input  logic [NUM_EXC-1:0] exc_report,
    input  logic               sf_report,
    input  logic [NUM_EXC-1:0] load_flags,
    input  logic               load_sf,
    output logic [NUM_EXC-1:0] flags,
    output logic               sf
);
    logic [NUM_EXC-1:0] flags_nx;
    logic               sf_nx;

    always_comb begin
        flags_nx = flags;
        sf_nx    = sf;
        unique case (op)
            OP_LOAD: begin
                flags_nx = load_flags;
                sf_nx    = load_sf;
            end
            OP_CLEAR: begin
                flags_nx = '0;
                sf_nx    = 1'b0;
            end
            OP_UPDATE: begin
                flags_nx = flags | exc_report;
                sf_nx    = sf | sf_report;
            end
            OP_IDLE: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            sf    <= 1'b0;
        end else begin
            flags <= flags_nx;
            sf    <= sf_nx;
        end
    end

    assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UPDATE || op == OP_IDLE) |=> ((flags & $past(flags)) == $past(flags)));
    assert_report_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UPDATE) |=> ((flags & $past(exc_report)) == $past(exc_report)));
    assert_clear_zeroes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (flags == '0 && !sf));
    assert_sf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UPDATE && sf_report) |=> sf);
endmodule

// File: rtl/nsw_field_reg.sv
module nsw_field_reg
    import nsw_pkg::*;
#(
    parameter int NUM_CC = CC_W,
    parameter int PTR_W  = TOP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  nsw_op_e           op,
    input  logic              cc_wr_en,
    input  logic [NUM_CC-1:0] cc_in,
    input  logic              sf_report,
    input  logic              sf_overflow,
    input  logic              top_wr_en,
    input  logic [PTR_W-1:0]  top_in,
    input  logic [NUM_CC-1:0] load_cc,
    input  logic [PTR_W-1:0]  load_top,
    output logic [NUM_CC-1:0] cc,
    output logic [PTR_W-1:0]  top
);
    localparam int DIR_IDX = 1;   // C1 carries stack-fault direction

    logic [NUM_CC-1:0] cc_nx;
    logic [PTR_W-1:0]  top_nx;

    always_comb begin
        cc_nx  = cc;
        top_nx = top;
        unique case (op)
            OP_LOAD: begin
                cc_nx  = load_cc;
                top_nx = load_top;
            end
            OP_UPDATE: begin
                if (cc_wr_en)
                    cc_nx = cc_in;
                if (sf_report)
                    cc_nx[DIR_IDX] = sf_overflow;
                if (top_wr_en)
                    top_nx = top_in;
            end
            OP_CLEAR, OP_IDLE: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc  <= '0;
            top <= '0;
        end else begin
            cc  <= cc_nx;
            top <= top_nx;
        end
    end

    assert_top_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UPDATE && top_wr_en) |=> (top == $past(top_in)));
    assert_sf_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UPDATE && sf_report) |=> (cc[DIR_IDX] == $past(sf_overflow)));
    assert_clear_keeps_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> ($stable(cc) && $stable(top)));
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> ($stable(cc) && $stable(top)));
endmodule

// File: rtl/nsw_summary.sv
module nsw_summary #(
    parameter int NUM_EXC = 6
) (
    input  logic [NUM_EXC-1:0] flags,
    input  logic [NUM_EXC-1:0] mask,
    output logic               es
);
    logic [NUM_EXC-1:0] live;

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_live
        assign live[i] = flags[i] & ~mask[i];
    end

    assign es = |live;

    always_comb begin
        assert_es_needs_flag_R3: assert (!es || (flags != '0));
    end
endmodule

// File: rtl/nsw_status_unit.sv
module nsw_status_unit
    import nsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EXC_W-1:0]    exc_report,
    input  logic                sf_report,
    input  logic                sf_overflow,
    input  logic                cc_wr_en,
    input  logic [CC_W-1:0]     cc_in,
    input  logic                top_wr_en,
    input  logic [TOP_W-1:0]    top_in,
    input  logic                clear_en,
    input  logic                load_en,
    input  logic [WORD_W-1:0]   load_word,
    input  logic [EXC_W-1:0]    exc_mask,
    output logic [WORD_W-1:0]   status_word,
    output logic                error_out
);
    nsw_op_e          op;
    logic             any_update;
    logic [EXC_W-1:0] flags;
    logic             sf;
    logic [CC_W-1:0]  cc;
    logic [TOP_W-1:0] top;
    logic             es;
    logic [CC_W-1:0]  load_cc;
    logic             unused_load_summary;

    assign any_update = (|exc_report) | sf_report | cc_wr_en | top_wr_en;
    assign load_cc = {load_word[C3_BIT], load_word[C2_BIT],
                      load_word[C1_BIT], load_word[C0_BIT]};
    // Restored summary bits are discarded; they are recomputed below
    assign unused_load_summary = load_word[ES_BIT] ^ load_word[B_BIT];

    nsw_cmd_sel u_sel (
        .load_en    (load_en),
        .clear_en   (clear_en),
        .any_update (any_update),
        .op         (op)
    );

    nsw_flag_reg #(.NUM_EXC(EXC_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .exc_report (exc_report),
        .sf_report  (sf_report),
        .load_flags (load_word[EXC_W-1:0]),
        .load_sf    (load_word[SF_BIT]),
        .flags      (flags),
        .sf         (sf)
    );

    nsw_field_reg #(.NUM_CC(CC_W), .PTR_W(TOP_W)) u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .cc_wr_en    (cc_wr_en),
        .cc_in       (cc_in),
        .sf_report   (sf_report),
        .sf_overflow (sf_overflow),
        .top_wr_en   (top_wr_en),
        .top_in      (top_in),
        .load_cc     (load_cc),
        .load_top    (load_word[TOP_MSB:TOP_LSB]),
        .cc          (cc),
        .top         (top)
    );

    nsw_summary #(.NUM_EXC(EXC_W)) u_sum (
        .flags (flags),
        .mask  (exc_mask),
        .es    (es)
    );

    always_comb begin
        status_word                   = '0;
        status_word[EXC_W-1:0]        = flags;
        status_word[SF_BIT]           = sf;
        status_word[ES_BIT]           = es;
        status_word[C0_BIT]           = cc[0];
        status_word[C1_BIT]           = cc[1];
        status_word[C2_BIT]           = cc[2];
        status_word[TOP_MSB:TOP_LSB]  = top;
        status_word[C3_BIT]           = cc[3];
        status_word[B_BIT]            = es;
    end

    assign error_out = es;

    assert_error_follows_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        error_out == (|(status_word[EXC_W-1:0] & ~exc_mask)));
    assert_load_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (status_word[14:8] == $past(load_word[14:8]) &&
                     status_word[6:0]  == $past(load_word[6:0])));
    assert_cc_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !clear_en && cc_wr_en && !sf_report) |=>
        ({status_word[C3_BIT], status_word[C2_BIT], status_word[C1_BIT],
          status_word[C0_BIT]} == $past(cc_in)));
endmodule

// File: tb/tb_nsw_status_unit.sv
module tb_nsw_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  exc_report = '0;
    logic        sf_report = 1'b0;
    logic        sf_overflow = 1'b0;
    logic        cc_wr_en = 1'b0;
    logic [3:0]  cc_in = '0;
    logic        top_wr_en = 1'b0;
    logic [2:0]  top_in = '0;
    logic        clear_en = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_word = '0;
    logic [5:0]  exc_mask = 6'h3F;
    logic [15:0] status_word;
    logic        error_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic [5:0] m_flags = '0;
    logic       m_sf = 1'b0;
    logic [3:0] m_cc = '0;
    logic [2:0] m_top = '0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    nsw_status_unit dut (
        .clk(clk), .rst_n(rst_n), .exc_report(exc_report), .sf_report(sf_report),
        .sf_overflow(sf_overflow), .cc_wr_en(cc_wr_en), .cc_in(cc_in),
        .top_wr_en(top_wr_en), .top_in(top_in), .clear_en(clear_en),
        .load_en(load_en), .load_word(load_word), .exc_mask(exc_mask),
        .status_word(status_word), .error_out(error_out)
    );

    function automatic logic [16:0] model_out(input logic [5:0] mask);
        logic es;
        logic [15:0] w;
        es = |(m_flags & ~mask);
        w = {es, m_cc[3], m_top, m_cc[2], m_cc[1], m_cc[0], es, m_sf, m_flags};
        return {es, w};
    endfunction

    task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: word=%h err=%b expected word=%h err=%b",
                     tag, got[15:0], got[16], exp[15:0], exp[16]);
        end
    endtask

    // driver: applies one cycle of requests at the falling edge and queues the expectation
    task automatic step(input string tag, input logic [5:0] rep, input logic sfr,
                        input logic ovf, input logic ccw, input logic [3:0] ccv,
                        input logic tw, input logic [2:0] tv, input logic clr,
                        input logic ld, input logic [15:0] lw, input logic [5:0] mask);
        @(negedge clk);
        exc_report = rep; sf_report = sfr; sf_overflow = ovf;
        cc_wr_en = ccw; cc_in = ccv; top_wr_en = tw; top_in = tv;
        clear_en = clr; load_en = ld; load_word = lw; exc_mask = mask;
        if (ld) begin
            m_flags = lw[5:0]; m_sf = lw[6];
            m_cc = {lw[14], lw[10], lw[9], lw[8]}; m_top = lw[13:11];
        end else if (clr) begin
            m_flags = '0; m_sf = 1'b0;
        end else begin
            m_flags = m_flags | rep;
            if (sfr) m_sf = 1'b1;
            if (ccw) m_cc = ccv;
            if (sfr) m_cc[1] = ovf;
            if (tw) m_top = tv;
        end
        exp_q.push_back(model_out(mask));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag, input logic [5:0] mask);
        step(tag, 6'h00, 0, 0, 0, 4'h0, 0, 3'd0, 0, 0, 16'h0000, mask);
    endtask

    // mask-only change, checked in the same cycle with no edge in between
    task automatic mask_now(input string tag, input logic [5:0] mask);
        @(negedge clk);
        exc_report = '0; sf_report = 0; cc_wr_en = 0; top_wr_en = 0;
        clear_en = 0; load_en = 0;
        exc_mask = mask;
        #1;
        check(tag, {error_out, status_word}, model_out(mask));
    endtask

    // monitor: compares after each capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0)
                check(tag_q.pop_front(), {error_out, status_word}, exp_q.pop_front());
        end
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #7;
        check("R1 in reset", {error_out, status_word}, 17'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after release", 6'h3F);

        step("R2 report masked", 6'h01, 0, 0, 0, 4'h0, 0, 3'd0, 0, 0, 16'h0, 6'h3F);
        step("R2 sticky or", 6'h04, 0, 0, 0, 4'h0, 0, 3'd0, 0, 0, 16'h0, 6'h3F);
        mask_now("R5 unmask bit0", 6'h3E);
        mask_now("R3 remask", 6'h3F);
        mask_now("R4 unmask bit2", 6'h3B);
        step("R6 cc write", 6'h00, 0, 0, 1, 4'b1011, 0, 3'd0, 0, 0, 16'h0, 6'h3B);
        step("R7 top write", 6'h00, 0, 0, 0, 4'h0, 1, 3'd5, 0, 0, 16'h0, 6'h3B);
        step("R8 overflow over C1", 6'h00, 1, 1, 1, 4'b0100, 0, 3'd0, 0, 0, 16'h0, 6'h3B);
        step("R8 underflow", 6'h00, 1, 0, 0, 4'h0, 0, 3'd0, 0, 0, 16'h0, 6'h3B);
        idle("R12 hold", 6'h3B);
        step("R11 clear beats reports", 6'h3F, 1, 1, 1, 4'hF, 1, 3'd1, 1, 0, 16'h0, 6'h00);
        step("R9 load summary ignored", 6'h00, 0, 0, 0, 4'h0, 0, 3'd0, 0, 1, 16'hFFC0, 6'h00);
        step("R9 load masked flags", 6'h00, 0, 0, 0, 4'h0, 0, 3'd0, 0, 1, 16'h80BF, 6'h3F);
        mask_now("R5 unmask after load", 6'h1F);
        step("R9 load asserts error", 6'h00, 0, 0, 0, 4'h0, 0, 3'd0, 0, 1, 16'h2010, 6'h00);
        step("R10 load beats clear", 6'h21, 1, 1, 1, 4'hF, 1, 3'd7, 1, 1, 16'h4A02, 6'h00);
        step("R2 report bit5", 6'h20, 0, 0, 0, 4'h0, 0, 3'd0, 0, 0, 16'h0, 6'h1F);
        idle("R12 hold again", 6'h1F);
        step("R11 clear drops error", 6'h00, 0, 0, 0, 4'h0, 0, 3'd0, 1, 0, 16'h0, 6'h00);
        idle("R12 final", 6'h00);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule